// File: doc/BRIEF.md
# Windowless Watchdog Reset Timer

This block watches over running software and produces a short active-low system reset pulse when the software stops servicing it. A fixed prescaler divides the CPU clock into ticks. Each tick steps a 7-bit down-counter. That counter sits in the low seven bits of an 8-bit control register, and the top bit of the register is the enable. The reset is requested when the counter's most significant bit clears, which happens on the step from 40h to 3Fh. Software therefore has to reload a value that has bit 6 set. The low six bits of that value choose one of 64 timeout steps.

Software writes and reads the control register through a simple strobe-and-data port. Two configuration inputs come from a non-volatile option store. One selects an always-on hardware mode. The other makes a halt indication reset the system. After the pulse, the surrounding reset network is expected to reset the whole chip, this block included.

Top module: `wdg_reset_timer`

## Requirements
- R1: The counter steps down exactly once every PRESCALE clock cycles. A register write clears the prescaler, so the first step after a write comes PRESCALE cycles after the write edge. A write in the same cycle as a prescaler expiry takes priority, and no step occurs in that cycle.
- R2: The control register has the enable in bit 7 and the counter in bits 6:0. A write loads wr_data[6:0] into the counter at the write edge.
- R3: While enabled, the counter step from 40h to 3Fh drives rst_out_n low from that clock edge onward.
- R4: A reset pulse holds rst_out_n low for exactly PULSE_CYCLES clock cycles, after which rst_out_n returns high.
- R5: A write with bit 6 = 0 starts a reset pulse at the write edge when the block is already enabled or when the written bit 7 is 1.
- R6: Once bit 7 has been written as 1, it stays 1 until rst_n. A later write with bit 7 = 0 does not disable the block.
- R7: With hw_wdg_en = 1 the block is enabled without any write, and rd_data[7] reads 1. After reset the counter is 7Fh and the prescaler is 0, so the first reset pulse starts 64·PRESCALE cycles after rst_n is released.
- R8: halt_exec = 1 with halt_rst_en = 1 starts a reset pulse at that edge, whether or not the block is enabled. halt_exec with halt_rst_en = 0 has no effect on rst_out_n.
- R9: While the block is disabled, the counter keeps stepping and wraps from 00h to 7Fh, but no counter value produces a reset pulse.
- R10: rd_data returns {enable, live counter}. After rst_n, rd_data is 7Fh (with hw_wdg_en = 0) and rst_out_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | {enable, counter} read value |
| hw_wdg_en | input | 1 | Option: hardware watchdog always enabled |
| halt_rst_en | input | 1 | Option: a halt causes a reset |
| halt_exec | input | 1 | A halt instruction is executing this cycle |
| rst_out_n | output | 1 | Active-low reset pulse |

## Verification
A write shows up in rd_data right after its edge. A T6-clear write or an enabled halt drops rst_out_n at that same edge. A timeout drops rst_out_n at the edge that ends the 64th prescaler period of the countdown, and the line rises again PULSE_CYCLES edges later. The bench drives its inputs on falling edges and updates a behavioural model on rising edges. On every falling edge it compares both outputs with the model, so each result is judged in the cycle it falls due. Directed checks also count falling edges from each stimulus and test the exact edge where a pulse starts and where it ends. One of these counts covers the full 512-cycle hardware-mode timeout.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int CTRL_W = 8;
    localparam int CNT_W  = CTRL_W - 1;
    typedef logic [CTRL_W-1:0] ctrl_t;
    typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int DIV = 12288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] count;
    } pre_s;

    pre_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (clear) begin
            st_d.count = '0;
        end else if (st_q.count == LAST) begin
            st_d.count = '0;
            tick       = 1'b1;
        end else begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1
    prescale_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.count == '0));
endmodule

// File: rtl/wdg_ctrl_counter.sv
module wdg_ctrl_counter
    import wdg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  wr_en,
    input  ctrl_t wr_data,
    input  logic  hw_mode,
    output logic  en_eff,
    output cnt_t  count,
    output logic  expire
);
    localparam int   T6  = CNT_W - 1;
    localparam cnt_t THR = cnt_t'(1) << T6;

    typedef struct packed {
        logic en;
        cnt_t cnt;
    } ctl_s;

    ctl_s st_d, st_q;

    assign en_eff = st_q.en | hw_mode;
    assign count  = st_q.cnt;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (wr_en) begin
            st_d.en  = st_q.en | wr_data[CTRL_W-1];
            st_d.cnt = wr_data[CNT_W-1:0];
            expire   = (en_eff | wr_data[CTRL_W-1]) & ~wr_data[T6];
        end else if (tick) begin
            st_d.cnt = st_q.cnt - 1'b1;
            expire   = en_eff & (st_q.cnt == THR);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en  <= 1'b0;
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.en |=> st_q.en);
    // R2
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.cnt == $past(wr_data[CNT_W-1:0])));
endmodule

// File: rtl/wdg_pulse_gen.sv
module wdg_pulse_gen #(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse_n
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LOAD = CW'(WIDTH);

    typedef struct packed {
        logic [CW-1:0] left;
    } pg_s;

    pg_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire)                 st_d.left = LOAD;
        else if (st_q.left != '0) st_d.left = st_q.left - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_n = (st_q.left == '0);

    // R3
    fire_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !pulse_n);
    // R4
    pulse_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && st_q.left == CW'(1)) |=> pulse_n);
endmodule

// File: rtl/wdg_reset_timer.sv
module wdg_reset_timer
    import wdg_pkg::*;
#(
    parameter int PRESCALE     = 12288,
    parameter int PULSE_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic        hw_wdg_en,
    input  logic        halt_rst_en,
    input  logic        halt_exec,
    output logic        rst_out_n
);
    logic tick, en_eff, expire, fire;
    cnt_t count;

    wdg_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(wr_en), .tick(tick)
    );

    wdg_ctrl_counter u_ctl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_data(wr_data), .hw_mode(hw_wdg_en),
        .en_eff(en_eff), .count(count), .expire(expire)
    );

    assign fire = expire | (halt_exec & halt_rst_en);

    wdg_pulse_gen #(.WIDTH(PULSE_CYCLES)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(fire), .pulse_n(rst_out_n)
    );

    assign rd_data = {en_eff, count};

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_eff && rst_out_n && !(wr_en && wr_data[7]) && !(halt_exec && halt_rst_en))
        |=> rst_out_n);
    // R8
    halt_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out_n && !halt_rst_en && !en_eff && !wr_en) |=> rst_out_n);
endmodule

// File: tb/tb_wdg_reset_timer.sv
module tb_wdg_reset_timer;
    localparam int P  = 8;
    localparam int PW = 4;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic hw = 1'b0, halt_en = 1'b0, halt = 1'b0;
    logic [7:0] rd_data;
    logic rst_out_n;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    wdg_reset_timer #(.PRESCALE(P), .PULSE_CYCLES(PW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .hw_wdg_en(hw), .halt_rst_en(halt_en),
        .halt_exec(halt), .rst_out_n(rst_out_n)
    );

    always #2 clk = ~clk;

    // behavioural model
    int m_en, m_cnt, m_pre, m_pulse;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_cnt = 127; m_pre = 0; m_pulse = 0;
        end else begin
            int on; bit f;
            on = m_en | hw; f = 0;
            if (wr_en) begin
                if ((on || wr_data[7]) && !wr_data[6]) f = 1;
                if (wr_data[7]) m_en = 1;
                m_cnt = wr_data & 127; m_pre = 0;
            end else if (m_pre == P - 1) begin
                m_pre = 0;
                if (on && m_cnt == 64) f = 1;
                m_cnt = (m_cnt + 127) % 128;
            end else m_pre++;
            if (halt && halt_en) f = 1;
            if (f) m_pulse = PW; else if (m_pulse > 0) m_pulse--;
        end
    end

    always @(negedge clk) if (rst_n && !done) begin
        int exp_rd;
        exp_rd = ((m_en | hw) << 7) | m_cnt;
        checks += 2;
        if (rd_data !== 8'(exp_rd)) begin
            failures++;
            $display("FAIL R10 model rd_data act=%h exp=%h", rd_data, exp_rd);
        end
        if (rst_out_n !== (m_pulse == 0)) begin
            failures++;
            $display("FAIL R4 model rst_out_n act=%b exp=%b", rst_out_n, m_pulse == 0);
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_reset(input logic hwv);
        @(negedge clk); rst_n = 1'b0; hw = hwv;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        do_reset(1'b0);
        // R10 reset state
        chk("R10 reset rd", rd_data, 8'h7F);
        chk("R10 reset rst_out_n", {7'd0, rst_out_n}, 8'h01);

        // R9 disabled countdown through 40h->3Fh without a pulse
        wr(8'h41);
        wait_n(P);
        chk("R9 step to 40", rd_data, 8'h40);
        wait_n(P);
        chk("R9 step to 3F", rd_data, 8'h3F);
        chk("R9 no pulse", {7'd0, rst_out_n}, 8'h01);
        wr(8'h00);
        wait_n(P);
        chk("R9 wrap to 7F", rd_data, 8'h7F);

        // R1 prescaler cleared by write
        wr(8'h45); wait_n(3); wr(8'h45);
        wait_n(P - 1);
        chk("R1 no early step", rd_data, 8'h45);
        wait_n(1);
        chk("R1 step at PRESCALE", rd_data, 8'h44);

        // R2/R3/R4 enabled timeout
        wr(8'hC0);
        chk("R2 load", rd_data, 8'hC0);
        wait_n(P - 1);
        chk("R3 before rollover", {7'd0, rst_out_n}, 8'h01);
        wait_n(1);
        chk("R3 rollover low", {7'd0, rst_out_n}, 8'h00);
        chk("R3 counter 3F", rd_data, 8'hBF);
        wait_n(PW - 1);
        chk("R4 still low", {7'd0, rst_out_n}, 8'h00);
        wait_n(1);
        chk("R4 released", {7'd0, rst_out_n}, 8'h01);

        // R6 sticky enable
        wr(8'h7F);
        chk("R6 enable kept", rd_data, 8'hFF);
        chk("R6 no pulse", {7'd0, rst_out_n}, 8'h01);

        // R5 T6-clear write while enabled
        wr(8'h3F);
        chk("R5 immediate reset", {7'd0, rst_out_n}, 8'h00);
        wait_n(PW + 1);
        wr(8'hFF);

        // R8 halt
        @(negedge clk); halt = 1'b1; halt_en = 1'b0;
        @(negedge clk); halt = 1'b0;
        chk("R8 halt ignored", {7'd0, rst_out_n}, 8'h01);
        @(negedge clk); halt = 1'b1; halt_en = 1'b1;
        @(negedge clk); halt = 1'b0; halt_en = 1'b0;
        chk("R8 halt reset", {7'd0, rst_out_n}, 8'h00);
        wait_n(PW + 1);

        // R5 enabling write with T6 clear
        do_reset(1'b0);
        wr(8'h80);
        chk("R5 enable+T6 clear reset", {7'd0, rst_out_n}, 8'h00);

        // R7 hardware mode
        do_reset(1'b1);
        chk("R7 hw enable read", rd_data, 8'hFF);
        begin
            int n;
            n = 0;
            for (int i = 1; i <= 64 * P + 10; i++) begin
                @(negedge clk);
                if (!rst_out_n) begin n = i; break; end
            end
            checks++;
            if (n != 64 * P) begin
                failures++;
                $display("FAIL R7 timeout cycles act=%0d exp=%0d", n, 64 * P);
            end
        end
        wait_n(PW + 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(100000 * 4);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog timeout act=hung exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule